// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the time base of a PWM engine. A 16-bit counter advances once per prescaled count enable. The prescaler has two stages: a coarse stage that divides by a power of two, and a high-speed stage that divides by one or by an even number. The counter can count up, count down, count up-down (a triangle wave), or freeze. The period that bounds the count is held in an active register. New values reach that register either at once or through a pending copy, which is transferred when the counter reaches zero.

A single 16-bit control word holds the direction, the division ratios, the period load mode and the run behaviour. The run behaviour is one of three: free running, halting after one more count step, or halting when the current cycle comes back to zero. Two compare values are matched against the counter. The outputs are single-clock strobes for zero, period, compare A reached on an upward step, and compare B reached on an upward step. A comparator or action stage downstream uses these strobes, together with the live count, to shape the PWM waveforms.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, all strobes are low and the counter is halted. It stays halted at 0 until a control word with bit 15 set is written, whatever else has been written.
- R2: The control word is decoded as follows: bits 15:14 run field, bits 12:10 coarse divider, bits 9:7 high-speed divider, bit 3 load mode, bits 1:0 count mode. Bits 13, 6:4 and 2 are reserved and are written as zero.
- R3: In count mode 00 (up), each step advances the count by one. From the active period P the count returns to 0. `evt_prd` accompanies the step that reaches P and `evt_zero` accompanies the step that reaches 0.
- R4: In count mode 01 (down), a step from 0 reloads P (with `evt_prd`). Each other step decrements by one, and `evt_zero` marks arrival at 0.
- R5: In count mode 10 (up-down), the count rises to P and then falls to 0, repeating every 2·P steps.
- R6: In count mode 11 (freeze), the count holds its value and no strobe is raised.
- R7: `evt_cmpa_up` / `evt_cmpb_up` fire when a step brings the count to compare A / B while counting upward. The upward steps are every step in up mode, the rising steps in up-down mode, and the step that leaves 0 in up-down mode. These strobes never fire in down mode or on a falling step.
- R8: With load mode 0, a period write goes to a pending register. The active period takes the pending value on the step that brings the count to 0.
- R9: With load mode 1, a period write changes the active period in the same clock. If the count is already at or above the new period in up mode, the next step wraps it to 0.
- R10: The count advances once every (2^coarse) × (high-speed = 0 ? 1 : 2·high-speed) clocks.
- R11: Run field 00 lets exactly one more count step happen after the control write takes effect, then halts the counter.
- R12: Run field 01 keeps counting until a step lands on 0, then halts with the count at 0.
- R13: Each strobe is high for exactly one clock, and only in a clock that follows a count step.
- R14: A control write with bit 15 set (run field 10 or 11) clears a halt. Counting resumes with the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word |
| prd_we | input | 1 | Write strobe for the period |
| prd_wdata | input | CNT_W | Period value |
| cmpa_we | input | 1 | Write strobe for compare A |
| cmpa_wdata | input | CNT_W | Compare A value |
| cmpb_we | input | 1 | Write strobe for compare B |
| cmpb_wdata | input | CNT_W | Compare B value |
| cnt | output | CNT_W | Current count |
| evt_zero | output | 1 | Strobe: count stepped to zero |
| evt_prd | output | 1 | Strobe: count stepped to the active period |
| evt_cmpa_up | output | 1 | Strobe: count reached compare A on an upward step |
| evt_cmpb_up | output | 1 | Strobe: count reached compare B on an upward step |

## Verification
The checker assumes that the reserved control bits are always written as zero. It also relates each strobe to the register values of the preceding clock, because a compare or period write landing in the same clock as a step is judged against the old value. The stimulus respects both assumptions. Every control word is built by a helper that places only the named fields. Compare values are written only while the counter is halted. Period writes during counting happen only in the shadow-load and immediate-load scenarios, where the expected count sequence accounts for the write clock.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  localparam int CTL_W = 16;

  typedef enum logic [1:0] {
    CM_UP     = 2'b00,
    CM_DOWN   = 2'b01,
    CM_UPDOWN = 2'b10,
    CM_HOLD   = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    RM_ONE_STEP  = 2'b00,
    RM_END_CYCLE = 2'b01,
    RM_FREE_ALT  = 2'b10,
    RM_FREE      = 2'b11
  } run_mode_e;

  // Control word layout; the fields are decoded by position.
  typedef struct packed {
    run_mode_e  run;     // 15:14
    logic       rsv13;   // 13
    logic [2:0] coarse;  // 12:10
    logic [2:0] fine;    // 9:7
    logic [2:0] rsv6_4;  // 6:4
    logic       imm;     // 3
    logic       rsv2;    // 2
    cnt_mode_e  mode;    // 1:0
  } ctl_t;

endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic [PS_W-1:0] coarse,
  input  logic [PS_W-1:0] fine,
  output logic            tick
);
  localparam int HS_W = $clog2(2 * ((1 << PS_W) - 1) + 1);
  localparam int CO_W = (1 << PS_W) - 1;

  logic [HS_W-1:0] hs_cnt, hs_last;
  logic [CO_W-1:0] co_cnt, co_last;
  logic            hs_wrap, co_wrap;

  always_comb begin
    hs_last = (fine == '0) ? '0 : HS_W'({fine, 1'b0} - 1'b1);
    co_last = CO_W'((1 << coarse) - 1);
    hs_wrap = (hs_cnt >= hs_last);
    co_wrap = (co_cnt >= co_last);
    tick    = run_en & hs_wrap & co_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      hs_cnt <= '0;
      co_cnt <= '0;
    end else begin
      hs_cnt <= hs_wrap ? '0 : hs_cnt + 1'b1;
      if (hs_wrap) begin
        co_cnt <= co_wrap ? '0 : co_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             imm,
  input  logic             zero_step,
  output logic [CNT_W-1:0] prd_act
);
  logic [CNT_W-1:0] prd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_pend <= '0;
      prd_act  <= '0;
    end else begin
      if (wr) begin
        prd_pend <= wdata;
      end
      if (wr && imm) begin
        prd_act <= wdata;
      end else if (zero_step && !imm) begin
        prd_act <= prd_pend;
      end
    end
  end

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt,
  output logic             step,
  output logic             up_step,
  output logic             zero_step
);
  logic dir_down, dir_nxt;

  always_comb begin
    nxt     = cnt;
    up_step = 1'b0;
    dir_nxt = dir_down;
    unique case (mode)
      CM_UP: begin
        up_step = 1'b1;
        nxt     = (cnt >= prd) ? '0 : cnt + 1'b1;
      end
      CM_DOWN: begin
        nxt = (cnt == '0) ? prd : cnt - 1'b1;
      end
      CM_UPDOWN: begin
        if (!dir_down) begin
          if (cnt >= prd) begin
            dir_nxt = 1'b1;
            nxt     = (cnt == '0) ? '0 : cnt - 1'b1;
          end else begin
            up_step = 1'b1;
            nxt     = cnt + 1'b1;
          end
        end else begin
          if (cnt == '0) begin
            dir_nxt = 1'b0;
            up_step = 1'b1;
            nxt     = (prd == '0) ? '0 : CNT_W'(1);
          end else begin
            nxt = cnt - 1'b1;
          end
        end
      end
      default: nxt = cnt;
    endcase
    step      = tick && (mode != CM_HOLD);
    zero_step = step && (nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else if (step) begin
      cnt      <= nxt;
      dir_down <= dir_nxt;
    end
  end

endmodule

// File: rtl/pwm_tb_events.sv
module pwm_tb_events #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             up_step,
  input  logic [CNT_W-1:0] nxt,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb,
  output logic             evt_zero,
  output logic             evt_prd,
  output logic             evt_cmpa_up,
  output logic             evt_cmpb_up
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_zero    <= 1'b0;
      evt_prd     <= 1'b0;
      evt_cmpa_up <= 1'b0;
      evt_cmpb_up <= 1'b0;
    end else begin
      evt_zero    <= step && (nxt == '0);
      evt_prd     <= step && (nxt == prd);
      evt_cmpa_up <= step && up_step && (nxt == cmpa);
      evt_cmpb_up <= step && up_step && (nxt == cmpb);
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [15:0]      ctl_wdata,
  input  logic             prd_we,
  input  logic [CNT_W-1:0] prd_wdata,
  input  logic             cmpa_we,
  input  logic [CNT_W-1:0] cmpa_wdata,
  input  logic             cmpb_we,
  input  logic [CNT_W-1:0] cmpb_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             evt_zero,
  output logic             evt_prd,
  output logic             evt_cmpa_up,
  output logic             evt_cmpb_up
);
  ctl_t             ctl_q;
  logic [CNT_W-1:0] cmpa_q, cmpb_q, prd_act, nxt;
  logic             halted_q, tick, step, up_step, zero_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (ctl_we)  ctl_q  <= ctl_t'(ctl_wdata);
      if (cmpa_we) cmpa_q <= cmpa_wdata;
      if (cmpb_we) cmpb_q <= cmpb_wdata;
    end
  end

  // Halt state: a free-run write wins over a stop condition in the same clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b1;
    end else if (ctl_we && ctl_wdata[CTL_W-1]) begin
      halted_q <= 1'b0;
    end else if (tick && ((ctl_q.run == RM_ONE_STEP) ||
                          ((ctl_q.run == RM_END_CYCLE) && zero_step))) begin
      halted_q <= 1'b1;
    end
  end

  pwm_tb_prescale #(.PS_W(PS_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run_en (!halted_q),
    .coarse (ctl_q.coarse[PS_W-1:0]),
    .fine   (ctl_q.fine[PS_W-1:0]),
    .tick   (tick)
  );

  pwm_tb_period #(.CNT_W(CNT_W)) u_prd (
    .clk       (clk),
    .rst       (rst),
    .wr        (prd_we),
    .wdata     (prd_wdata),
    .imm       (ctl_q.imm),
    .zero_step (zero_step),
    .prd_act   (prd_act)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .mode      (ctl_q.mode),
    .prd       (prd_act),
    .cnt       (cnt),
    .nxt       (nxt),
    .step      (step),
    .up_step   (up_step),
    .zero_step (zero_step)
  );

  pwm_tb_events #(.CNT_W(CNT_W)) u_evt (
    .clk         (clk),
    .rst         (rst),
    .step        (step),
    .up_step     (up_step),
    .nxt         (nxt),
    .prd         (prd_act),
    .cmpa        (cmpa_q),
    .cmpb        (cmpb_q),
    .evt_zero    (evt_zero),
    .evt_prd     (evt_prd),
    .evt_cmpa_up (evt_cmpa_up),
    .evt_cmpb_up (evt_cmpb_up)
  );

endmodule

// File: rtl/pwm_timebase_checker.sv
module pwm_timebase_checker
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input ctl_t             ctl_q,
  input logic             halted_q,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] cmpa_q,
  input logic [CNT_W-1:0] cmpb_q,
  input logic [CNT_W-1:0] cnt,
  input logic             evt_zero,
  input logic             evt_prd,
  input logic             evt_cmpa_up,
  input logic             evt_cmpb_up
);
  logic any_evt;
  assign any_evt = evt_zero | evt_prd | evt_cmpa_up | evt_cmpb_up;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.rsv13 == 1'b0) && (ctl_q.rsv6_4 == 3'b000) && (ctl_q.rsv2 == 1'b0)); // R2

  AST_ZERO_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    evt_zero |-> (cnt == '0)); // R3

  AST_PRD_AT_PRD: assert property (@(posedge clk) disable iff (rst)
    evt_prd |-> (cnt == $past(prd_act))); // R3

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.mode == CM_HOLD) |=> $stable(cnt)); // R6

  AST_CMPA_UP_ONLY: assert property (@(posedge clk) disable iff (rst)
    evt_cmpa_up |-> ((cnt == $past(cmpa_q)) && ($past(ctl_q.mode) != CM_DOWN))); // R7

  AST_CMPB_UP_ONLY: assert property (@(posedge clk) disable iff (rst)
    evt_cmpb_up |-> ((cnt == $past(cmpb_q)) && ($past(ctl_q.mode) != CM_DOWN))); // R7

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> $stable(cnt)); // R11

  AST_NO_EVT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (halted_q || (ctl_q.mode == CM_HOLD)) |=> !any_evt); // R13

endmodule

bind pwm_timebase pwm_timebase_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_q       (ctl_q),
  .halted_q    (halted_q),
  .prd_act     (prd_act),
  .cmpa_q      (cmpa_q),
  .cmpb_q      (cmpb_q),
  .cnt         (cnt),
  .evt_zero    (evt_zero),
  .evt_prd     (evt_prd),
  .evt_cmpa_up (evt_cmpa_up),
  .evt_cmpb_up (evt_cmpb_up)
);

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
  localparam int W = 16;
  localparam logic [1:0] M_UP = 2'b00, M_DOWN = 2'b01, M_UPDN = 2'b10, M_HOLD = 2'b11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1;
  logic         ctl_we = 1'b0, prd_we = 1'b0, cmpa_we = 1'b0, cmpb_we = 1'b0;
  logic [15:0]  ctl_wdata = '0;
  logic [W-1:0] prd_wdata = '0, cmpa_wdata = '0, cmpb_wdata = '0;
  logic [W-1:0] cnt;
  logic         evt_zero, evt_prd, evt_cmpa_up, evt_cmpb_up;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  pwm_timebase u_pwm_timebase (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .prd_we(prd_we), .prd_wdata(prd_wdata),
    .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata),
    .cmpb_we(cmpb_we), .cmpb_wdata(cmpb_wdata),
    .cnt(cnt), .evt_zero(evt_zero), .evt_prd(evt_prd),
    .evt_cmpa_up(evt_cmpa_up), .evt_cmpb_up(evt_cmpb_up)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // R2 field placement: run 15:14, coarse 12:10, fine 9:7, load mode 3, count mode 1:0
  function automatic logic [15:0] ctlw(logic [1:0] run, logic [2:0] co, logic [2:0] fi,
                                       logic imm, logic [1:0] mode);
    return {run, 1'b0, co, fi, 3'b000, imm, 1'b0, mode};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_ctl(logic [15:0] v);
    ctl_we = 1'b1; ctl_wdata = v; cyc(); ctl_we = 1'b0;
  endtask
  task automatic wr_prd(logic [W-1:0] v);
    prd_we = 1'b1; prd_wdata = v; cyc(); prd_we = 1'b0;
  endtask
  task automatic wr_cmp(logic [W-1:0] a, logic [W-1:0] b);
    cmpa_we = 1'b1; cmpa_wdata = a; cmpb_we = 1'b1; cmpb_wdata = b;
    cyc(); cmpa_we = 1'b0; cmpb_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; repeat (3) cyc(); rst = 1'b0;
  endtask

  task automatic start_run(logic [1:0] mode, int p, int ca, int cb, logic [2:0] co, logic [2:0] fi);
    do_reset();
    wr_ctl(ctlw(2'b00, co, fi, 1'b1, mode));
    wr_prd(W'(p));
    wr_cmp(W'(ca), W'(cb));
    wr_ctl(ctlw(2'b11, co, fi, 1'b1, mode));
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 cnt after reset", cnt, 0);
    check("R1 strobes after reset", {evt_zero, evt_prd, evt_cmpa_up, evt_cmpb_up}, 0);
    wr_ctl(ctlw(2'b00, 3'd0, 3'd0, 1'b1, M_UP));
    wr_prd(W'(5));
    repeat (6) cyc();
    check("R1 still halted without bit 15", cnt, 0);
    wr_ctl(ctlw(2'b01, 3'd0, 3'd0, 1'b1, M_UP));
    repeat (4) cyc();
    check("R1 run field 01 does not start", cnt, 0);
  endtask

  task automatic t_up();
    start_run(M_UP, 4, 2, 3, 3'd0, 3'd0);
    for (int k = 1; k <= 10; k++) begin
      int e;
      cyc();
      e = k % 5;
      check("R3 up count", cnt, e);
      check("R3 up zero strobe", evt_zero, int'(e == 0));
      check("R3 up period strobe", evt_prd, int'(e == 4));
      check("R7 up cmpa strobe", evt_cmpa_up, int'(e == 2));
      check("R7 up cmpb strobe", evt_cmpb_up, int'(e == 3));
    end
  endtask

  task automatic t_down();
    start_run(M_DOWN, 4, 2, 3, 3'd0, 3'd0);
    for (int k = 1; k <= 10; k++) begin
      int e;
      cyc();
      e = 4 - ((k - 1) % 5);
      check("R4 down count", cnt, e);
      check("R4 down period strobe", evt_prd, int'(e == 4));
      check("R4 down zero strobe", evt_zero, int'(e == 0));
      check("R7 no cmpa in down mode", evt_cmpa_up, 0);
      check("R7 no cmpb in down mode", evt_cmpb_up, 0);
    end
  endtask

  task automatic t_updown();
    start_run(M_UPDN, 3, 2, 3, 3'd0, 3'd0);
    for (int k = 1; k <= 12; k++) begin
      int pos, e;
      cyc();
      pos = k % 6;
      e = (pos <= 3) ? pos : 6 - pos;
      check("R5 updown count", cnt, e);
      check("R5 updown zero strobe", evt_zero, int'(pos == 0));
      check("R5 updown period strobe", evt_prd, int'(pos == 3));
      check("R7 cmpa only rising", evt_cmpa_up, int'(pos == 2));
      check("R7 cmpb at top rising", evt_cmpb_up, int'(pos == 3));
    end
  endtask

  task automatic t_freeze();
    start_run(M_UP, 9, 20, 20, 3'd0, 3'd0);
    repeat (3) cyc();
    wr_ctl(ctlw(2'b11, 3'd0, 3'd0, 1'b1, M_HOLD));
    check("R6 last step before freeze", cnt, 4);
    for (int k = 0; k < 5; k++) begin
      cyc();
      check("R6 frozen count", cnt, 4);
      check("R6 no strobes frozen", {evt_zero, evt_prd, evt_cmpa_up, evt_cmpb_up}, 0);
    end
  endtask

  task automatic t_stop_step();
    int c0;
    start_run(M_UP, 9, 20, 20, 3'd0, 3'd0);
    repeat (2) cyc();
    c0 = cnt;
    wr_ctl(ctlw(2'b00, 3'd0, 3'd0, 1'b1, M_UP));
    cyc();
    check("R11 one step after stop", cnt, (c0 + 2) % 10);
    for (int k = 0; k < 6; k++) begin
      cyc();
      check("R11 halted count", cnt, (c0 + 2) % 10);
      check("R13 no strobe while halted", {evt_zero, evt_prd}, 0);
    end
    wr_ctl(ctlw(2'b10, 3'd0, 3'd0, 1'b1, M_UP));
    check("R14 no step in write clock", cnt, (c0 + 2) % 10);
    cyc();
    check("R14 resumes with run 10", cnt, (c0 + 3) % 10);
  endtask

  task automatic t_stop_cycle();
    int zeros;
    start_run(M_UP, 9, 20, 20, 3'd0, 3'd0);
    repeat (3) cyc();
    wr_ctl(ctlw(2'b01, 3'd0, 3'd0, 1'b1, M_UP));
    check("R12 counting continues", cnt, 4);
    zeros = 0;
    for (int k = 0; k < 20; k++) begin
      cyc();
      if (evt_zero) zeros++;
    end
    check("R12 halted at zero", cnt, 0);
    check("R12 exactly one wrap", zeros, 1);
  endtask

  task automatic t_shadow();
    int mx, guard;
    start_run(M_UP, 4, 20, 20, 3'd0, 3'd0);
    wr_ctl(ctlw(2'b11, 3'd0, 3'd0, 1'b0, M_UP));
    guard = 0;
    while (cnt != 1 && guard < 20) begin cyc(); guard++; end
    wr_prd(W'(7));
    mx = cnt; guard = 0;
    cyc();
    while (!evt_zero && guard < 30) begin
      if (cnt > mx) mx = cnt;
      cyc(); guard++;
    end
    check("R8 old period until zero", mx, 4);
    mx = 0; guard = 0;
    cyc();
    while (!evt_zero && guard < 30) begin
      if (cnt > mx) mx = cnt;
      cyc(); guard++;
    end
    check("R8 pending period after zero", mx, 7);
  endtask

  task automatic t_immediate();
    int guard;
    start_run(M_UP, 9, 20, 20, 3'd0, 3'd0);
    guard = 0;
    while (cnt != 6 && guard < 20) begin cyc(); guard++; end
    wr_prd(W'(3));
    check("R9 step in write clock", cnt, 7);
    cyc();
    check("R9 wraps above new period", cnt, 0);
    check("R9 zero strobe on wrap", evt_zero, 1);
    check("R9 no period strobe on wrap", evt_prd, 0);
    repeat (3) cyc();
    check("R9 new period reached", cnt, 3);
    check("R9 period strobe at new period", evt_prd, 1);
  endtask

  task automatic t_prescale(logic [2:0] co, logic [2:0] fi, int div);
    int prev, n, guard;
    start_run(M_UP, 1000, 2000, 2000, co, fi);
    prev = cnt; guard = 0;
    while (cnt == prev && guard < 200) begin cyc(); guard++; end
    prev = cnt; n = 0;
    do begin cyc(); n++; end while (cnt == prev && n < 200);
    check("R10 R2 prescale interval", n, div);
  endtask

  task automatic t_strobe_width();
    int hi;
    start_run(M_UP, 1, 20, 20, 3'd1, 3'd2);
    hi = 0;
    for (int k = 0; k < 64; k++) begin
      cyc();
      if (evt_zero) hi++;
    end
    check("R13 zero strobe clocks in 8 steps", hi, 4);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    cyc();
    t_reset();
    t_up();
    t_down();
    t_updown();
    t_freeze();
    t_stop_step();
    t_stop_cycle();
    t_shadow();
    t_immediate();
    t_prescale(3'd1, 3'd2, 8);
    t_prescale(3'd0, 3'd3, 6);
    t_prescale(3'd2, 3'd0, 4);
    t_strobe_width();
    done = 1'b1;
    report();
    $finish;
  end

endmodule